// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block runs the write side of a serial NOR flash over a single-bit SPI link in clock mode 0. A host presents a command: an opcode, a 24-bit byte address and a length. The engine then runs the whole device handshake by itself. It waits until the flash reports idle and sets the write latch in a transaction of its own. It then sends the program or erase command with its address and streams the payload bytes, which it pulls one at a time through a valid/ready port. Finally it polls the device again until the internal operation has finished. One pulse on `cmd_done` closes the operation.

Serial clock timing comes from the system clock through the divider `DIV`, which must be 2 or more. Each bit lasts `DIV` cycles: the first `DIV/2` cycles with the serial clock low and the rest with it high. Chip select stays high for at least `DIV` cycles between transactions. A program request longer than one page is cut to the page size. An erase address is forced down to its sector boundary.

The controller has nine states. `ST_IDLE` waits for a command: a supported opcode goes to `ST_GAP`, and any other opcode stays in `ST_IDLE` and pulses the error flag. `ST_GAP` holds chip select high until the guard time has passed, then lowers it and enters the state held in the resume register. `ST_POLL_OP` sends the status-read opcode and moves to `ST_POLL_RD`, which clocks in the status byte and raises chip select. If the busy bit is set, the engine returns through `ST_GAP` to `ST_POLL_OP`. If the pre-command poll reads idle, it goes through `ST_GAP` to `ST_WREN`. If the post-command poll reads idle, it goes to `ST_FINISH`. `ST_WREN` sends write-enable and returns through `ST_GAP` to `ST_CMD`. `ST_CMD` sends the opcode and moves to `ST_ADDR`. After three address bytes `ST_ADDR` goes to `ST_DATA` when there is payload to send; otherwise it closes the transaction and goes through `ST_GAP` to the post-command poll. `ST_DATA` does the same close after the last byte. `ST_FINISH` pulses done and returns to `ST_IDLE`.

Top module: `nor_write_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sclk`, `cmd_busy`, `cmd_done`, `cmd_err` and `wr_ready` are all 0.
- R2: Mode 0 clocking. `spi_sclk` is 0 whenever `spi_cs_n` is 1. Each high phase of `spi_sclk` lasts DIV - DIV/2 cycles. `spi_mosi` changes only while `spi_sclk` is 0. Every byte goes out most significant bit first, and every transaction contains a whole number of bytes.
- R3: Before the write-enable, the engine polls status with transactions of two bytes: opcode 0x05 followed by 8 read clocks, with chip select raised after each. It repeats the poll until bit 0 of the status byte (the busy bit) reads 0. The other status bits have no effect.
- R4: Write-enable is a one-byte transaction holding opcode 0x06. It comes after the pre-command poll and directly before the command transaction.
- R5: Page program (opcode 0x02) is one transaction. It carries 0x02, then address bits 23:16, 15:8 and 7:0, then the payload bytes in the order they were received.
- R6: A program length above 256 sends exactly 256 payload bytes. A length of 0 sends only the opcode and address.
- R7: Sector erase (opcode 0x20) is a four-byte transaction carrying the address with bits 11:0 cleared. `cmd_len` is ignored, and no payload bytes are fetched.
- R8: After the command transaction, the status poll of R3 runs again. `cmd_done` is then high for exactly one cycle. `cmd_busy` is 1 from the cycle after the command is accepted through the done cycle, and 0 after it.
- R9: Between the rise of `spi_cs_n` and its next fall, `spi_cs_n` stays high for at least DIV clock cycles.
- R10: `wr_ready` is 1 only while a transaction is open and the engine needs a payload byte. A byte is taken in a cycle where `wr_valid` and `wr_ready` are both 1. While `wr_valid` is 0, the serial clock stays low.
- R11: A command whose opcode is neither 0x02 nor 0x20 is ignored. `cmd_err` is 1 for exactly the one cycle after it, `cmd_busy` stays 0 and chip select does not fall.
- R12: A `cmd_valid` pulse while `cmd_busy` is 1 has no effect. It raises no error and adds no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request; sampled only while idle |
| cmd_op | input | 8 | Opcode: 0x02 program, 0x20 sector erase |
| cmd_addr | input | 24 | Flash byte address |
| cmd_len | input | LEN_W | Program length in bytes (clamped to PAGE_BYTES) |
| cmd_busy | output | 1 | Operation in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle pulse on an unsupported opcode |
| wr_data | input | 8 | Payload byte |
| wr_valid | input | 1 | Payload byte available |
| wr_ready | output | 1 | Engine takes a payload byte this cycle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A fault in the state register or the resume register shows up on the pins. The transaction classes come out in a different order, or an extra or missing status poll appears, and the bench compares the order of classes once each operation finishes. A fault in the byte shifter or the divider shows up within one bit period: a serial clock high while chip select is high, a high phase of the wrong length, or a data line moving while the clock is high. The bench checks these on every clock. A fault in the address or length registers shows up only when the captured command bytes are compared, or when the count of bytes taken through the payload handshake is checked at the end of the operation.

// File: rtl/nwe_pkg.sv
package nwe_pkg;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_ERASE = 8'h20;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_WREN,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/nwe_bit_timer.sv
module nwe_bit_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_hi,
    output logic bit_last
);
    localparam int PW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [PW-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (!run) begin
            ph <= '0;
        end else if (ph == PW'(DIV - 1)) begin
            ph <= '0;
        end else begin
            ph <= ph + PW'(1);
        end
    end

    assign sclk_hi  = run && (ph >= PW'(HALF));
    assign bit_last = run && (ph == PW'(DIV - 1));
endmodule

// File: rtl/nwe_byte_shifter.sv
module nwe_byte_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic       rx_bit,
    output logic       sclk,
    output logic       mosi
);
    logic       active;
    logic [2:0] cnt;
    logic [7:0] sh;
    logic       done_q;
    logic       rx_q;
    logic       sclk_hi;
    logic       bit_last;

    nwe_bit_timer #(.DIV(DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .sclk_hi  (sclk_hi),
        .bit_last (bit_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            done_q <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (start) begin
                    sh     <= tx_byte;
                    cnt    <= '0;
                    active <= 1'b1;
                end
            end else if (bit_last) begin
                rx_q <= miso;
                if (cnt == 3'd7) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt <= cnt + 3'd1;
                    sh  <= {sh[6:0], 1'b0};
                end
            end
        end
    end

    assign busy   = active;
    assign done   = done_q;
    assign rx_bit = rx_q;
    assign sclk   = sclk_hi;
    assign mosi   = sh[7];

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/nwe_cs_guard.sv
module nwe_cs_guard #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic gap_ok
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= CW'(DIV);
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != CW'(DIV)) begin
            hi_cnt <= hi_cnt + CW'(1);
        end
    end

    assign gap_ok = (hi_cnt == CW'(DIV));
endmodule

// File: rtl/nor_write_engine.sv
module nor_write_engine
    import nwe_pkg::*;
#(
    parameter int DIV          = 4,
    parameter int LEN_W        = 12,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [23:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             cmd_busy,
    output logic             cmd_done,
    output logic             cmd_err,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int CNT_W = $clog2(PAGE_BYTES) + 1;
    localparam logic [23:0] SECT_MASK = 24'(SECTOR_BYTES - 1);

    seq_state_t       state, nstate, resume;
    logic             cs_n_q;
    logic [7:0]       op_q;
    logic [23:0]      addr_q;
    logic [CNT_W-1:0] remain;
    logic             post_q;
    logic             armed;
    logic [1:0]       aidx;
    logic             err_q;

    logic             sh_start, sh_busy, sh_done, sh_rx;
    logic [7:0]       sh_tx;
    logic             gap_ok;
    logic             op_ok, byte_state, can_launch, prog_more;
    logic [CNT_W-1:0] len_clamped;

    nwe_byte_shifter #(.DIV(DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_bit  (sh_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    nwe_cs_guard #(.DIV(DIV)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n_q),
        .gap_ok (gap_ok)
    );

    assign op_ok       = (cmd_op == OP_PROG) || (cmd_op == OP_ERASE);
    assign len_clamped = (cmd_len > LEN_W'(PAGE_BYTES)) ? CNT_W'(PAGE_BYTES)
                                                        : CNT_W'(cmd_len);
    assign prog_more   = (op_q == OP_PROG) && (remain != '0);

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid && op_ok) nstate = ST_GAP;
            ST_GAP:     if (gap_ok) nstate = resume;
            ST_POLL_OP: if (sh_done) nstate = ST_POLL_RD;
            ST_POLL_RD: if (sh_done) nstate = (!sh_rx && post_q) ? ST_FINISH : ST_GAP;
            ST_WREN:    if (sh_done) nstate = ST_GAP;
            ST_CMD:     if (sh_done) nstate = ST_ADDR;
            ST_ADDR:    if (sh_done && aidx == 2'd2) nstate = prog_more ? ST_DATA : ST_GAP;
            ST_DATA:    if (sh_done && remain == CNT_W'(1)) nstate = ST_GAP;
            ST_FINISH:  nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    // state register and per-operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            resume <= ST_POLL_OP;
            cs_n_q <= 1'b1;
            op_q   <= '0;
            addr_q <= '0;
            remain <= '0;
            post_q <= 1'b0;
            armed  <= 1'b0;
            aidx   <= '0;
            err_q  <= 1'b0;
        end else begin
            state <= nstate;
            err_q <= (state == ST_IDLE) && cmd_valid && !op_ok;
            if (sh_start) armed <= 1'b1;
            if (sh_done)  armed <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid && op_ok) begin
                        op_q   <= cmd_op;
                        addr_q <= (cmd_op == OP_ERASE) ? (cmd_addr & ~SECT_MASK) : cmd_addr;
                        remain <= (cmd_op == OP_PROG) ? len_clamped : '0;
                        post_q <= 1'b0;
                        aidx   <= '0;
                        resume <= ST_POLL_OP;
                    end
                end
                ST_GAP: begin
                    if (gap_ok) cs_n_q <= 1'b0;
                end
                ST_POLL_RD: begin
                    if (sh_done) begin
                        cs_n_q <= 1'b1;
                        resume <= sh_rx ? ST_POLL_OP : ST_WREN;
                    end
                end
                ST_WREN: begin
                    if (sh_done) begin
                        cs_n_q <= 1'b1;
                        resume <= ST_CMD;
                    end
                end
                ST_ADDR: begin
                    if (sh_done) begin
                        addr_q <= {addr_q[15:0], 8'h00};
                        aidx   <= aidx + 2'd1;
                        if (aidx == 2'd2 && !prog_more) begin
                            cs_n_q <= 1'b1;
                            post_q <= 1'b1;
                            resume <= ST_POLL_OP;
                        end
                    end
                end
                ST_DATA: begin
                    if (sh_done) begin
                        remain <= remain - CNT_W'(1);
                        if (remain == CNT_W'(1)) begin
                            cs_n_q <= 1'b1;
                            post_q <= 1'b1;
                            resume <= ST_POLL_OP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        byte_state = (state == ST_POLL_OP) || (state == ST_POLL_RD) || (state == ST_WREN) ||
                     (state == ST_CMD) || (state == ST_ADDR) || (state == ST_DATA);
        can_launch = byte_state && !armed && !sh_busy;
        wr_ready   = (state == ST_DATA) && can_launch;
        sh_start   = (state == ST_DATA) ? (wr_ready && wr_valid) : can_launch;
        unique case (state)
            ST_POLL_OP: sh_tx = OP_RDSR;
            ST_WREN:    sh_tx = OP_WREN;
            ST_CMD:     sh_tx = op_q;
            ST_ADDR:    sh_tx = addr_q[23:16];
            ST_DATA:    sh_tx = wr_data;
            default:    sh_tx = 8'h00;
        endcase
        spi_cs_n = cs_n_q;
        cmd_busy = (state != ST_IDLE);
        cmd_done = (state == ST_FINISH);
        cmd_err  = err_q;
    end

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(gap_ok));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> (!cmd_done && !cmd_busy));

    // R10
    ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!spi_cs_n && !spi_sclk));

    // R11
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!cmd_busy && spi_cs_n));
endmodule

// File: tb/tb_nor_write_engine.sv
module tb_nor_write_engine;
    localparam int DIV   = 4;
    localparam int LEN_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [7:0]       cmd_op = '0;
    logic [23:0]      cmd_addr = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic             cmd_busy, cmd_done, cmd_err;
    logic [7:0]       wr_data = '0;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic             spi_cs_n, spi_sclk, spi_mosi;
    logic             miso_r = 1'b0;

    always #4 clk = ~clk;

    nor_write_engine #(.DIV(DIV), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(miso_r)
    );

    int vecs = 0;
    int errs = 0;

    task automatic check(input bit ok, input string req, input string msg);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // ---------------- behavioural flash device ----------------
    int         bitcnt = 0;
    logic [7:0] cur = '0;
    logic [7:0] tx_q[$];
    logic [7:0] last_cmd[$];
    logic [7:0] status_now = '0;
    string      seq = "";
    int         wip_left = 0;
    int         post_busy = 0;
    int         cs_falls = 0;

    always @(negedge spi_cs_n) begin
        bitcnt = 0;
        tx_q.delete();
        cs_falls++;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        cur = {cur[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt % 8 == 0) begin
            tx_q.push_back(cur);
            // busy bit in bit 0, an unrelated bit set in bit 1
            if (bitcnt == 8) status_now = {6'b0, 1'b1, (wip_left > 0)};
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && tx_q.size() > 0 && tx_q[0] == 8'h05 && bitcnt >= 8 && bitcnt < 16)
            miso_r = status_now[15 - bitcnt];
    end

    always @(posedge spi_cs_n) if (rst_n) begin
        check(bitcnt % 8 == 0, "R2", $sformatf("whole bytes: actual %0d bits expected multiple of 8", bitcnt));
        if (tx_q.size() > 0) begin
            if (tx_q[0] == 8'h05) begin
                check(tx_q.size() == 2, "R3", $sformatf("poll length: actual %0d expected 2", tx_q.size()));
                seq = {seq, "P"};
                if (wip_left > 0) wip_left--;
            end else if (tx_q[0] == 8'h06) begin
                check(tx_q.size() == 1, "R4", $sformatf("write-enable length: actual %0d expected 1", tx_q.size()));
                seq = {seq, "W"};
            end else begin
                seq = {seq, "C"};
                last_cmd = tx_q;
                wip_left = post_busy;
            end
        end
    end

    // ---------------- per-clock protocol reference ----------------
    logic psclk = 1'b0, pmosi = 1'b0, pcs = 1'b1, pdone = 1'b0;
    int   cs_hi = 1000;
    int   hi_run = 0;

    always @(negedge clk) if (rst_n) begin
        check(!(spi_cs_n && spi_sclk), "R2", $sformatf("sclk with cs high: actual %0b expected 0", spi_sclk));
        if (psclk && spi_sclk && spi_mosi !== pmosi)
            check(0, "R2", $sformatf("mosi moved while sclk high: actual %0b expected %0b", spi_mosi, pmosi));
        if (psclk && !spi_sclk)
            check(hi_run == DIV - DIV/2, "R2", $sformatf("sclk high phase: actual %0d expected %0d", hi_run, DIV - DIV/2));
        hi_run = spi_sclk ? hi_run + 1 : 0;
        if (pcs && !spi_cs_n)
            check(cs_hi >= DIV, "R9", $sformatf("cs high time: actual %0d expected >= %0d", cs_hi, DIV));
        cs_hi = spi_cs_n ? cs_hi + 1 : 0;
        if (pdone && cmd_done) check(0, "R8", "done width: actual 2+ cycles expected 1");
        if (cmd_done && !cmd_busy) check(0, "R8", "busy during done: actual 0 expected 1");
        if (wr_ready && spi_cs_n) check(0, "R10", "ready with cs high: actual 1 expected 0");
        psclk = spi_sclk; pmosi = spi_mosi; pcs = spi_cs_n; pdone = cmd_done;
    end

    // ---------------- payload source ----------------
    logic [7:0] feed_q[$];
    int fed = 0;
    int stall_mode = 0;
    int fcyc = 0;

    always @(negedge clk) begin
        fcyc++;
        wr_valid = (feed_q.size() > 0) && (stall_mode == 0 || fcyc % 3 != 0);
        wr_data  = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
        if (wr_valid && wr_ready) begin
            void'(feed_q.pop_front());
            fed++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_done(input string req);
        int n = 0;
        while (!cmd_done && n < 40000) begin
            @(negedge clk);
            n++;
        end
        check(cmd_done == 1'b1, req, $sformatf("done seen: actual %0b expected 1", cmd_done));
        @(negedge clk);
        check(cmd_busy == 1'b0 && cmd_done == 1'b0, "R8",
              $sformatf("after done busy/done: actual %0b%0b expected 00", cmd_busy, cmd_done));
    endtask

    task automatic run_op(input logic [7:0] op, input logic [23:0] addr, input int len,
                          input int pre, input int post, input int stall, input bit intrude,
                          input string req);
        logic [7:0] data[$];
        logic [7:0] expb[$];
        logic [23:0] ea;
        string exps = "";
        int nsend;
        bit same;
        seq = "";
        wip_left = pre;
        post_busy = post;
        stall_mode = stall;
        fed = 0;
        feed_q.delete();
        nsend = (op == 8'h02) ? ((len > 256) ? 256 : len) : 0;
        for (int i = 0; i < len + 4; i++) begin
            data.push_back(8'((i * 37 + len) & 8'hff));
            feed_q.push_back(8'((i * 37 + len) & 8'hff));
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_len = LEN_W'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_busy == 1'b1, "R8", $sformatf("busy after accept: actual %0b expected 1", cmd_busy));
        if (intrude) begin
            repeat (100) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 8'h20; cmd_addr = 24'hFFFFFF;
            @(negedge clk);
            cmd_valid = 1'b0;
            check(cmd_err == 1'b0 && cmd_busy == 1'b1, "R12",
                  $sformatf("command while busy err/busy: actual %0b%0b expected 01", cmd_err, cmd_busy));
        end
        wait_done(req);
        for (int i = 0; i <= pre; i++) exps = {exps, "P"};
        exps = {exps, "WC"};
        for (int i = 0; i <= post; i++) exps = {exps, "P"};
        check(seq == exps, "R3", $sformatf("transaction order: actual %s expected %s", seq, exps));
        ea = (op == 8'h20) ? (addr & 24'hFFF000) : addr;
        expb.push_back(op);
        expb.push_back(ea[23:16]);
        expb.push_back(ea[15:8]);
        expb.push_back(ea[7:0]);
        for (int i = 0; i < nsend; i++) expb.push_back(data[i]);
        same = (last_cmd.size() == expb.size());
        if (same) for (int i = 0; i < expb.size(); i++) if (last_cmd[i] !== expb[i]) same = 0;
        check(same, req, $sformatf("command bytes: actual %0d bytes first %h expected %0d bytes first %h",
              last_cmd.size(), (last_cmd.size() > 0) ? last_cmd[0] : 8'hxx, expb.size(), expb[0]));
        check(fed == nsend, (op == 8'h02) ? "R6" : "R7",
              $sformatf("payload bytes taken: actual %0d expected %0d", fed, nsend));
        feed_q.delete();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL R8 watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        int falls0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && cmd_busy === 1'b0 && cmd_done === 1'b0 &&
              cmd_err === 1'b0 && wr_ready === 1'b0, "R1",
              $sformatf("reset outputs cs,sclk,busy,done,err,ready: actual %b%b%b%b%b%b expected 100000",
                        spi_cs_n, spi_sclk, cmd_busy, cmd_done, cmd_err, wr_ready));

        // R7 erase, busy on entry and after command, len ignored
        run_op(8'h20, 24'h123ABC, 7, 2, 3, 0, 0, "R7");
        // R5 program with stalls and an intruding command (R12)
        run_op(8'h02, 24'hA55A01, 5, 0, 1, 1, 1, "R5");
        // R6 clamp above page
        run_op(8'h02, 24'h000100, 300, 1, 2, 0, 0, "R6");
        // R6 zero length
        run_op(8'h02, 24'h7F0010, 0, 0, 0, 0, 0, "R6");
        // R10 single byte with stalls
        run_op(8'h02, 24'h00FFFF, 1, 0, 0, 1, 0, "R10");

        // R11 unsupported opcode
        falls0 = cs_falls;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 8'h03; cmd_addr = 24'h000000; cmd_len = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_err == 1'b1 && cmd_busy == 1'b0, "R11",
              $sformatf("err/busy after bad op: actual %0b%0b expected 10", cmd_err, cmd_busy));
        @(negedge clk);
        check(cmd_err == 1'b0, "R11", $sformatf("err width: actual %0b expected 0", cmd_err));
        repeat (40) @(negedge clk);
        check(cs_falls == falls0 && cmd_busy == 1'b0, "R11",
              $sformatf("cs falls after bad op: actual %0d expected %0d", cs_falls - falls0, 0));

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule